// File: doc/BRIEF.md
# Transmit DMA Channel Control and Status Unit

This block keeps the control state, credit accounting and shared status and error flags for a set of transmit DMA channels, each feeding its own transmit FIFO. Software programs each channel through a small register window. It sets a two-bit run mode, a credit-enable flag and the channel's credit count, and it reads back a shared status word and a sticky error word. A scheduler hands the unit activate commands, one channel at a time. Each channel can hold one command. A channel with a waiting command, run mode set to normal, credit mode on and a nonzero credit count issues one request strobe. The issue spends one credit and marks the channel busy until the data mover reports completion. The FIFO returns credits one strobe at a time.

Two hardware checks feed the sticky error word. One is a FIFO-full indication that arrives while the channel's credit count is not zero, which means the credit bookkeeping has drifted. The other is an activate command for a channel whose command slot is still occupied. Two more error flags are set from outside strobes that report a host dword-count mismatch and an internal memory address fault. Software clears the flags by writing ones to them.

Top module: `txdma_status_unit`

## Requirements
- R1: After reset every channel's control and credit registers read zero, the status word (address 0x100) reads 0xFFFF0000, the error word (address 0x104) reads zero and no request strobe is active.
- R2: The control register of channel c sits at byte address c*0x20, with run mode in bits 31:30 and credit enable in bit 3; all other bits read back as zero whatever was written.
- R3: A channel raises its `req_issue` bit for exactly one cycle, two clock edges after the activate command is accepted, and only when its command slot is full, nothing is in flight, its mode is 2'b10, credit enable is 1 and its credit count is above zero.
- R4: Run modes 2'b00 (off), 2'b01 (pause at frame end) and 2'b11 (reserved), or credit enable at 0, keep a waiting command in its slot without issuing it; switching to mode 2'b10 then issues it.
- R5: The credit count drops by one on each issue, rises by one on each `credit_ret` strobe, stays unchanged when both happen in the same cycle and saturates at its maximum (255) instead of wrapping.
- R6: Status bit 24+c is 1 while channel c has no transfer in flight (an issue clears it and `xfer_done` sets it again); status bit 16+c is 1 while the channel's command slot is empty.
- R7: Error bit c sets when `fifo_full[c]` is high while channel c's credit count is nonzero; a full indication at zero credit sets nothing.
- R8: Error bit 9+c sets when an activate command for channel c arrives while its slot is occupied; the new command is dropped and the earlier one is kept, so only one request is issued.
- R9: Error bit 30 sets on `host_len_err` and error bit 31 sets on `mem_addr_err`.
- R10: Error flags stay set until software writes 1 to them at address 0x104; writing 0 leaves a flag unchanged, and a new event in the same cycle as the clearing write keeps the flag set.
- R11: The credit register of channel c at byte address c*0x20+4 can be written and reads back the current count in its low 8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 9 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| act_valid | input | 1 | Scheduler activate command valid |
| act_chan | input | 3 | Channel targeted by the activate command |
| credit_ret | input | 8 | Per-channel credit return strobe from the FIFO |
| fifo_full | input | 8 | Per-channel FIFO-full indication |
| xfer_done | input | 8 | Per-channel completion of the in-flight transfer |
| host_len_err | input | 1 | Host dword-count mismatch event |
| mem_addr_err | input | 1 | Internal memory address fault event |
| req_issue | output | 8 | Per-channel one-cycle request strobe |

## Verification
The bench sweeps every channel through accept, issue, completion, zero-credit stall and credit-return resume. A design with a wrong credit gate either issues at zero credit or never resumes after a return. It exercises every run-mode code against a waiting command, so a design that runs in pause or reserved mode shows up as an early strobe. It fires a second activate into an occupied slot on each channel and counts the issues, which catches a design that overwrites or double-issues. The error checks cover full-at-zero-credit, a clearing write racing a new event, and zero-writes to the error word, which catch a flag that is not sticky, one that loses the race, or a clear that touches the wrong bits.

// File: rtl/txdma_pkg.sv
package txdma_pkg;

    typedef enum logic [1:0] {
        MODE_OFF       = 2'b00,
        MODE_PAUSE_EOF = 2'b01,
        MODE_RUN       = 2'b10,
        MODE_RSVD      = 2'b11
    } run_mode_e;

    typedef struct packed {
        run_mode_e mode;
        logic      credit_en;
    } chan_ctrl_t;

    localparam int CH_STRIDE    = 32'h20;
    localparam int OFS_CTRL     = 32'h0;
    localparam int OFS_CREDIT   = 32'h4;
    localparam int STATUS_ADDR  = 32'h100;
    localparam int ERROR_ADDR   = 32'h104;

    localparam int MODE_MSB     = 31;
    localparam int MODE_LSB     = 30;
    localparam int CEN_BIT      = 3;

    localparam int EMPTY_POS    = 24;
    localparam int IDLE_POS     = 16;
    localparam int ACT_ERR_POS  = 9;
    localparam int CRED_ERR_POS = 0;
    localparam int LEN_ERR_BIT  = 30;
    localparam int ADDR_ERR_BIT = 31;

    function automatic logic [31:0] pack_ctrl(input chan_ctrl_t c);
        logic [31:0] w;
        w = '0;
        w[MODE_MSB:MODE_LSB] = c.mode;
        w[CEN_BIT]           = c.credit_en;
        return w;
    endfunction

    function automatic chan_ctrl_t unpack_ctrl(input logic [1:0] m, input logic cen);
        chan_ctrl_t c;
        c.mode      = run_mode_e'(m);
        c.credit_en = cen;
        return c;
    endfunction

endpackage

// File: rtl/txdma_reg_decode.sv
module txdma_reg_decode
    import txdma_pkg::*;
#(
    parameter int NCH = 8,
    parameter int AW  = 9
) (
    input  logic          reg_we,
    input  logic [AW-1:0] reg_addr,
    output logic [NCH-1:0] ctrl_we,
    output logic [NCH-1:0] credit_we,
    output logic          err_we
);
    for (genvar c = 0; c < NCH; c++) begin : g_dec
        assign ctrl_we[c]   = reg_we && (reg_addr == AW'(c * CH_STRIDE + OFS_CTRL));
        assign credit_we[c] = reg_we && (reg_addr == AW'(c * CH_STRIDE + OFS_CREDIT));
    end

    assign err_we = reg_we && (reg_addr == AW'(ERROR_ADDR));
endmodule

// File: rtl/txdma_lane.sv
module txdma_lane
    import txdma_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ctrl_we,
    input  logic [1:0]    wr_mode,
    input  logic          wr_cen,
    input  logic          credit_we,
    input  logic [CW-1:0] wr_credit,
    input  logic          act_load,
    input  logic          credit_ret,
    input  logic          xfer_done,
    input  logic          fifo_full,
    output chan_ctrl_t    ctrl,
    output logic [CW-1:0] credit,
    output logic          pending,
    output logic          inflight,
    output logic          issue,
    output logic          cred_err_ev,
    output logic          act_err_ev
);
    localparam logic [CW-1:0] CMAX = '1;

    chan_ctrl_t    ctrl_q;
    logic [CW-1:0] credit_q;
    logic          pending_q, inflight_q, issue_q;
    logic          issue_ok;

    assign issue_ok = pending_q && !inflight_q && (ctrl_q.mode == MODE_RUN)
                      && ctrl_q.credit_en && (credit_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q     <= unpack_ctrl(2'b00, 1'b0);
            credit_q   <= '0;
            pending_q  <= 1'b0;
            inflight_q <= 1'b0;
            issue_q    <= 1'b0;
        end else begin
            if (ctrl_we)
                ctrl_q <= unpack_ctrl(wr_mode, wr_cen);

            if (credit_we)
                credit_q <= wr_credit;
            else if (issue_ok && !credit_ret)
                credit_q <= credit_q - 1'b1;
            else if (!issue_ok && credit_ret && credit_q != CMAX)
                credit_q <= credit_q + 1'b1;

            if (act_load && !pending_q)
                pending_q <= 1'b1;
            else if (issue_ok)
                pending_q <= 1'b0;

            if (issue_ok)
                inflight_q <= 1'b1;
            else if (xfer_done)
                inflight_q <= 1'b0;

            issue_q <= issue_ok;
        end
    end

    assign ctrl        = ctrl_q;
    assign credit      = credit_q;
    assign pending     = pending_q;
    assign inflight    = inflight_q;
    assign issue       = issue_q;
    assign cred_err_ev = fifo_full && (credit_q != '0);
    assign act_err_ev  = act_load && pending_q;
endmodule

// File: rtl/txdma_err_bank.sv
module txdma_err_bank
    import txdma_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] cred_ev,
    input  logic [NCH-1:0] act_ev,
    input  logic           len_ev,
    input  logic           addr_ev,
    input  logic           err_we,
    input  logic [31:0]    clr_mask,
    output logic [31:0]    err_q
);
    logic [31:0] set_vec, impl_mask, clr_vec;

    always_comb begin
        set_vec   = '0;
        impl_mask = '0;
        for (int c = 0; c < NCH; c++) begin
            set_vec[CRED_ERR_POS + c]  = cred_ev[c];
            set_vec[ACT_ERR_POS + c]   = act_ev[c];
            impl_mask[CRED_ERR_POS + c] = 1'b1;
            impl_mask[ACT_ERR_POS + c]  = 1'b1;
        end
        set_vec[LEN_ERR_BIT]    = len_ev;
        set_vec[ADDR_ERR_BIT]   = addr_ev;
        impl_mask[LEN_ERR_BIT]  = 1'b1;
        impl_mask[ADDR_ERR_BIT] = 1'b1;
        clr_vec = err_we ? clr_mask : '0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            err_q <= '0;
        else
            err_q <= ((err_q & ~clr_vec) | set_vec) & impl_mask;
    end
endmodule

// File: rtl/txdma_status_unit.sv
module txdma_status_unit
    import txdma_pkg::*;
#(
    parameter int NCH = 8,
    parameter int CW  = 8,
    parameter int AW  = 9
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   reg_we,
    input  logic [AW-1:0]          reg_addr,
    input  logic [31:0]            reg_wdata,
    output logic [31:0]            reg_rdata,
    input  logic                   act_valid,
    input  logic [$clog2(NCH)-1:0] act_chan,
    input  logic [NCH-1:0]         credit_ret,
    input  logic [NCH-1:0]         fifo_full,
    input  logic [NCH-1:0]         xfer_done,
    input  logic                   host_len_err,
    input  logic                   mem_addr_err,
    output logic [NCH-1:0]         req_issue
);
    localparam int CHW = $clog2(NCH);

    logic [NCH-1:0]    ctrl_we, credit_we;
    logic              err_we;
    chan_ctrl_t        ctrl     [NCH];
    logic [CW-1:0]     credit   [NCH];
    logic [NCH-1:0]    pend_vec, busy_vec, cred_ev, act_ev;
    logic [NCH*CW-1:0] credit_flat;
    logic [31:0]       err_q, status;

    txdma_reg_decode #(.NCH(NCH), .AW(AW)) u_dec (
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .ctrl_we   (ctrl_we),
        .credit_we (credit_we),
        .err_we    (err_we)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_lane
        txdma_lane #(.CW(CW)) u_lane (
            .clk         (clk),
            .rst         (rst),
            .ctrl_we     (ctrl_we[c]),
            .wr_mode     (reg_wdata[MODE_MSB:MODE_LSB]),
            .wr_cen      (reg_wdata[CEN_BIT]),
            .credit_we   (credit_we[c]),
            .wr_credit   (reg_wdata[CW-1:0]),
            .act_load    (act_valid && (act_chan == CHW'(c))),
            .credit_ret  (credit_ret[c]),
            .xfer_done   (xfer_done[c]),
            .fifo_full   (fifo_full[c]),
            .ctrl        (ctrl[c]),
            .credit      (credit[c]),
            .pending     (pend_vec[c]),
            .inflight    (busy_vec[c]),
            .issue       (req_issue[c]),
            .cred_err_ev (cred_ev[c]),
            .act_err_ev  (act_ev[c])
        );
        assign credit_flat[c*CW +: CW] = credit[c];
    end

    txdma_err_bank #(.NCH(NCH)) u_err (
        .clk      (clk),
        .rst      (rst),
        .cred_ev  (cred_ev),
        .act_ev   (act_ev),
        .len_ev   (host_len_err),
        .addr_ev  (mem_addr_err),
        .err_we   (err_we),
        .clr_mask (reg_wdata),
        .err_q    (err_q)
    );

    always_comb begin
        status = '0;
        for (int c = 0; c < NCH; c++) begin
            status[EMPTY_POS + c] = !busy_vec[c];
            status[IDLE_POS + c]  = !pend_vec[c];
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == AW'(STATUS_ADDR))
            reg_rdata = status;
        else if (reg_addr == AW'(ERROR_ADDR))
            reg_rdata = err_q;
        for (int c = 0; c < NCH; c++) begin
            if (reg_addr == AW'(c * CH_STRIDE + OFS_CTRL))
                reg_rdata = pack_ctrl(ctrl[c]);
            if (reg_addr == AW'(c * CH_STRIDE + OFS_CREDIT))
                reg_rdata = 32'(credit[c]);
        end
    end
endmodule

// File: rtl/txdma_status_unit_chk.sv
module txdma_status_unit_chk
    import txdma_pkg::*;
#(
    parameter int NCH = 8,
    parameter int CW  = 8,
    parameter int AW  = 9
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   reg_we,
    input logic [AW-1:0]          reg_addr,
    input logic [31:0]            reg_wdata,
    input logic [$clog2(NCH)-1:0] act_chan,
    input logic                   act_valid,
    input logic [NCH-1:0]         fifo_full,
    input logic                   host_len_err,
    input logic                   mem_addr_err,
    input logic [NCH-1:0]         req_issue,
    input logic [NCH-1:0]         pend_vec,
    input logic [NCH*CW-1:0]      credit_flat,
    input logic [31:0]            err_q
);
    localparam int CHW = $clog2(NCH);

    // R3: a channel never strobes in two consecutive cycles
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
        (req_issue & $past(req_issue)) == '0);

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        // R3: an issue only follows a nonzero credit count
        a_r3_needs_credit: assert property (@(posedge clk) disable iff (rst)
            req_issue[c] |-> $past(credit_flat[c*CW +: CW]) != '0);

        // R7: full with credit left flags desynchronization
        a_r7_credit_desync: assert property (@(posedge clk) disable iff (rst)
            (fifo_full[c] && credit_flat[c*CW +: CW] != '0) |=> err_q[CRED_ERR_POS + c]);

        // R8: activate into an occupied slot flags an error
        a_r8_slot_busy: assert property (@(posedge clk) disable iff (rst)
            (act_valid && act_chan == CHW'(c) && pend_vec[c]) |=> err_q[ACT_ERR_POS + c]);
    end

    // R9: external fault strobes land in bits 30 and 31
    a_r9_len_flag: assert property (@(posedge clk) disable iff (rst)
        host_len_err |=> err_q[LEN_ERR_BIT]);
    a_r9_addr_flag: assert property (@(posedge clk) disable iff (rst)
        mem_addr_err |=> err_q[ADDR_ERR_BIT]);

    for (genvar b = 0; b < 32; b++) begin : g_bit
        // R10: a flag only drops after a one written to it
        a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
            $fell(err_q[b]) |->
                $past(reg_we && reg_addr == AW'(ERROR_ADDR) && reg_wdata[b]));
    end
endmodule

bind txdma_status_unit txdma_status_unit_chk #(.NCH(NCH), .CW(CW), .AW(AW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .reg_we       (reg_we),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .act_chan     (act_chan),
    .act_valid    (act_valid),
    .fifo_full    (fifo_full),
    .host_len_err (host_len_err),
    .mem_addr_err (mem_addr_err),
    .req_issue    (req_issue),
    .pend_vec     (pend_vec),
    .credit_flat  (credit_flat),
    .err_q        (err_q)
);

// File: tb/txdma_status_unit_test.sv
module txdma_status_unit_test;
    localparam int STAT = 32'h100;
    localparam int ERRA = 32'h104;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [8:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        act_valid = 1'b0;
    logic [2:0]  act_chan = '0;
    logic [7:0]  credit_ret = '0;
    logic [7:0]  fifo_full = '0;
    logic [7:0]  xfer_done = '0;
    logic        host_len_err = 1'b0;
    logic        mem_addr_err = 1'b0;
    logic [7:0]  req_issue;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    txdma_status_unit uut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .act_valid(act_valid),
        .act_chan(act_chan), .credit_ret(credit_ret), .fifo_full(fifo_full),
        .xfer_done(xfer_done), .host_len_err(host_len_err),
        .mem_addr_err(mem_addr_err), .req_issue(req_issue)
    );

    always #5 clk = ~clk;

    function automatic int ctl_a(input int c); return c * 32; endfunction
    function automatic int crd_a(input int c); return c * 32 + 4; endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        reg_addr = 9'(a);
        #1;
        d = reg_rdata;
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 9'(a); reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic act(input int c);
        @(negedge clk);
        act_valid = 1'b1; act_chan = 3'(c);
        @(negedge clk);
        act_valid = 1'b0;
    endtask

    task automatic done_pulse(input int c);
        @(negedge clk);
        xfer_done[c] = 1'b1;
        @(negedge clk);
        xfer_done[c] = 1'b0;
    endtask

    task automatic count_issues(input int c, input int n, output int cnt);
        cnt = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (req_issue[c]) cnt++;
        end
    endtask

    initial begin
        logic [31:0] d;
        int n;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        for (int c = 0; c < 8; c++) begin
            rd(ctl_a(c), d); chk("R1 ctrl", d, 32'h0);
            rd(crd_a(c), d); chk("R1 credit", d, 32'h0);
        end
        rd(STAT, d); chk("R1 status", d, 32'hFFFF_0000);
        rd(ERRA, d); chk("R1 error", d, 32'h0);
        chk("R1 issue", 32'(req_issue), 32'h0);

        // R2 and R11: register layout and credit load
        for (int c = 0; c < 8; c++) begin
            wr(ctl_a(c), 32'hFFFF_FFFF);
            rd(ctl_a(c), d); chk("R2 reserved masked", d, 32'hC000_0008);
            wr(ctl_a(c), 32'h4000_0000);
            rd(ctl_a(c), d); chk("R2 mode field", d, 32'h4000_0000);
            wr(crd_a(c), 32'(c + 10));
            rd(crd_a(c), d); chk("R11 credit load", d, 32'(c + 10));
        end

        // R3, R5, R6: per-channel issue cycle, stall at zero credit, resume
        for (int c = 0; c < 8; c++) begin
            wr(ctl_a(c), 32'h8000_0008);
            wr(crd_a(c), 32'd2);
            act(c);
            rd(STAT, d); chk("R6 slot full", 32'(d[16 + c]), 32'd0);
            chk("R3 not yet", 32'(req_issue), 32'h0);
            @(negedge clk);
            chk("R3 strobe", 32'(req_issue), 32'(1 << c));
            rd(crd_a(c), d); chk("R5 decrement", d, 32'd1);
            rd(STAT, d);
            chk("R6 busy", 32'(d[24 + c]), 32'd0);
            chk("R6 slot empty", 32'(d[16 + c]), 32'd1);
            @(negedge clk);
            chk("R3 one cycle", 32'(req_issue), 32'h0);
            done_pulse(c);
            rd(STAT, d); chk("R6 done", 32'(d[24 + c]), 32'd1);

            act(c);
            count_issues(c, 3, n); chk("R3 second issue", 32'(n), 32'd1);
            rd(crd_a(c), d); chk("R5 to zero", d, 32'd0);
            done_pulse(c);

            act(c);
            count_issues(c, 4, n); chk("R3 zero credit stall", 32'(n), 32'd0);
            rd(STAT, d); chk("R3 waiting", 32'(d[16 + c]), 32'd0);
            @(negedge clk); credit_ret[c] = 1'b1;
            @(negedge clk); credit_ret[c] = 1'b0;
            count_issues(c, 4, n); chk("R3 resume", 32'(n), 32'd1);
            done_pulse(c);
            rd(STAT, d); chk("R6 idle", d, 32'hFFFF_0000);
            rd(ERRA, d); chk("R8 no spurious", d, 32'h0);
        end

        // R4: non-running modes and credit disabled hold the command
        wr(crd_a(0), 32'd3);
        wr(ctl_a(0), 32'h0000_0008);
        act(0);
        for (int m = 0; m < 4; m++) begin
            if (m == 2) continue;
            wr(ctl_a(0), 32'(m) << 30 | 32'h8);
            count_issues(0, 4, n); chk("R4 mode holds", 32'(n), 32'd0);
        end
        wr(ctl_a(0), 32'h8000_0000);
        count_issues(0, 4, n); chk("R4 credit off holds", 32'(n), 32'd0);
        rd(STAT, d); chk("R4 still waiting", 32'(d[16]), 32'd0);
        wr(ctl_a(0), 32'h8000_0008);
        count_issues(0, 4, n); chk("R4 run issues", 32'(n), 32'd1);
        done_pulse(0);

        // R5: issue and return together, then saturation
        wr(ctl_a(2), 32'h8000_0008);
        wr(crd_a(2), 32'd5);
        @(negedge clk); act_valid = 1'b1; act_chan = 3'd2; credit_ret[2] = 1'b1;
        @(negedge clk); act_valid = 1'b0;
        @(negedge clk); credit_ret[2] = 1'b0;
        chk("R5 issue with return", 32'(req_issue), 32'h4);
        rd(crd_a(2), d); chk("R5 net count", d, 32'd6);
        done_pulse(2);
        wr(crd_a(2), 32'd254);
        @(negedge clk); credit_ret[2] = 1'b1;
        repeat (3) @(negedge clk);
        credit_ret[2] = 1'b0;
        rd(crd_a(2), d); chk("R5 saturate", d, 32'd255);

        // R7: credit desynchronization per channel
        for (int c = 0; c < 8; c++) begin
            wr(crd_a(c), 32'd0);
            @(negedge clk); fifo_full[c] = 1'b1;
            @(negedge clk); fifo_full[c] = 1'b0;
            rd(ERRA, d); chk("R7 zero credit quiet", d, 32'h0);
            wr(crd_a(c), 32'd1);
            @(negedge clk); fifo_full[c] = 1'b1;
            @(negedge clk); fifo_full[c] = 1'b0;
            rd(ERRA, d); chk("R7 desync flag", d, 32'(1 << c));
            wr(ERRA, 32'(1 << c));
            rd(ERRA, d); chk("R10 clear", d, 32'h0);
        end

        // R8: activate into occupied slot
        for (int c = 0; c < 8; c++) begin
            wr(ctl_a(c), 32'h0000_0008);
            wr(crd_a(c), 32'd1);
            act(c);
            act(c);
            rd(ERRA, d); chk("R8 busy slot flag", d, 32'(1 << (9 + c)));
            wr(ctl_a(c), 32'h8000_0008);
            count_issues(c, 4, n); chk("R8 single issue", 32'(n), 32'd1);
            rd(STAT, d); chk("R8 slot drained", 32'(d[16 + c]), 32'd1);
            done_pulse(c);
            wr(ERRA, 32'(1 << (9 + c)));
            rd(ERRA, d); chk("R10 clear", d, 32'h0);
        end

        // R9 and R10: external flags, zero-write, partial clear, race
        @(negedge clk); host_len_err = 1'b1;
        @(negedge clk); host_len_err = 1'b0;
        rd(ERRA, d); chk("R9 length flag", d, 32'h4000_0000);
        @(negedge clk); mem_addr_err = 1'b1;
        @(negedge clk); mem_addr_err = 1'b0;
        rd(ERRA, d); chk("R9 address flag", d, 32'hC000_0000);
        wr(ERRA, 32'h0);
        rd(ERRA, d); chk("R10 zero write", d, 32'hC000_0000);
        wr(ERRA, 32'h4000_0000);
        rd(ERRA, d); chk("R10 partial clear", d, 32'h8000_0000);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 9'(ERRA); reg_wdata = 32'h8000_0000; mem_addr_err = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; mem_addr_err = 1'b0;
        rd(ERRA, d); chk("R10 set wins", d, 32'h8000_0000);
        wr(ERRA, 32'h8000_0000);
        rd(ERRA, d); chk("R10 final clear", d, 32'h0);

        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule